// File: doc/BRIEF.md
# Lookup-Table Constant Multiplier

This block multiplies an incoming unsigned operand by a fixed coefficient. It does not use a gate-level multiplier. Instead it reads precomputed multiples of the coefficient out of writable table memory and sums them. Two table banks of 256 entries each, 24 bits per entry, hold those multiples. A host fills them through a write port, which stays open while products are being formed, so the coefficient can be swapped at run time.

The operand mode is chosen per operation:

- **Short-coefficient mode.** An 8-bit coefficient scales a 16-bit operand. The two operand bytes address the two banks at the same time. The high-byte lookup is shifted left by eight bits and added to the low-byte lookup.
- **Long-coefficient mode.** A 16-bit coefficient scales an 8-bit operand. Only the low operand byte is used, and it addresses bank 0, whose entries are the full 24-bit products.

An input register and an output register can each be switched in by parameter to shorten the timing paths. A valid flag travels alongside the data through every stage.

Top module: `lut_kmul`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_product` is 0.
- R2: With `in_mode` = 0 the result is (bank1[operand[15:8]] << 8) + bank0[operand[7:0]], truncated to 24 bits. When bank b holds k·i at address i for an 8-bit k, the result equals k·operand.
- R3: With `in_mode` = 1 the result is bank0[operand[7:0]], and operand bits 15:8 have no effect on it.
- R4: A write cycle (`wr_en` = 1) stores `wr_data` at `wr_addr`. It goes into bank 0 when `wr_bank` bit 0 is set, and into bank 1 when bit 1 is set. Both bits set writes both banks.
- R5: Each accepted operand gives exactly one `out_valid` pulse, in issue order, 1 + IN_REG + OUT_REG cycles after it was presented. With the default parameters that is 3 cycles.
- R6: Table writes are accepted while operands stream. An entry written in one cycle is seen by every lookup presented in a later cycle.
- R7: Arithmetic is unsigned with no overflow at the extremes: 255 × 65535 and 65535 × 255 both give 16711425.
- R8: `out_product` keeps its last value while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_mode | input | 1 | 0: 8-bit coefficient × 16-bit operand; 1: 16-bit coefficient × 8-bit operand |
| in_operand | input | 16 | Unsigned operand |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | 2 | Bank select mask (bit 0 bank 0, bit 1 bank 1) |
| wr_addr | input | 8 | Table entry address |
| wr_data | input | 24 | Table entry value |
| out_valid | output | 1 | Product valid |
| out_product | output | 24 | Unsigned product |

## Verification
The write-visibility property assumes that the host never writes an entry in the same cycle as a lookup that needs the new value. The stimulus guarantees this by always leaving at least one cycle between a table write and any operand that depends on it.

The hold and valid-follow properties assume that reset is held for at least two clock edges. The stimulus holds reset for several cycles before the first operand.

Operands are swept across the full 16-bit range in one mode and across all 256 low bytes, with scrambled high bytes, in the other. Back-to-back issue exercises the pipeline at full rate.

// File: rtl/lut_kmul_pkg.sv
package lut_kmul_pkg;
  typedef enum logic {
    MODE_SHORT_COEF = 1'b0,
    MODE_LONG_COEF  = 1'b1
  } kmode_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/lut_kmul_instage.sv
module lut_kmul_instage
  import lut_kmul_pkg::*;
#(
  parameter int OP_W   = 16,
  parameter bit REG_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_valid,
  input  kmode_e          i_mode,
  input  logic [OP_W-1:0] i_operand,
  output logic            o_valid,
  output kmode_e          o_mode,
  output logic [OP_W-1:0] o_operand
);
  generate
    if (REG_EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          o_valid   <= 1'b0;
          o_mode    <= MODE_SHORT_COEF;
          o_operand <= '0;
        end else begin
          o_valid <= i_valid;
          if (i_valid) begin
            o_mode    <= i_mode;
            o_operand <= i_operand;
          end
        end
      end

      // R5: the input register adds exactly one cycle
      a_r5_in_follow: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);
      a_r5_in_quiet: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);
    end else begin : g_pass
      assign o_valid   = i_valid;
      assign o_mode    = i_mode;
      assign o_operand = i_operand;
    end
  endgenerate
endmodule

// File: rtl/lut_kmul_bank.sv
module lut_kmul_bank #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  // R6: a lookup issued the cycle after a write returns the written entry
  a_r6_write_visible: assert property (@(posedge clk) disable iff (rst)
    wr_en ##1 (rd_en && rd_addr == $past(wr_addr)) |=> rd_data == $past(wr_data, 2));
endmodule

// File: rtl/lut_kmul_sum.sv
module lut_kmul_sum
  import lut_kmul_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int PROD_W = 24,
  parameter bit REG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  input  kmode_e            i_mode,
  input  logic [PROD_W-1:0] i_lo,
  input  logic [PROD_W-1:0] i_hi,
  output logic              o_valid,
  output logic [PROD_W-1:0] o_product
);
  logic [PROD_W-1:0] hi_shifted;
  logic [PROD_W-1:0] sum;

  always_comb begin
    hi_shifted = i_hi << SEG_W;
    if (i_mode == MODE_LONG_COEF) sum = i_lo;
    else                          sum = hi_shifted + i_lo;
  end

  generate
    if (REG_EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          o_valid   <= 1'b0;
          o_product <= '0;
        end else begin
          o_valid <= i_valid;
          if (i_valid) o_product <= sum;
        end
      end

      // R5: the output register adds one cycle
      a_r5_out_follow: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);
      // R8: no arriving result leaves the product unchanged
      a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> $stable(o_product));
    end else begin : g_pass
      assign o_valid   = i_valid;
      assign o_product = sum;
    end
  endgenerate
endmodule

// File: rtl/lut_kmul.sv
module lut_kmul
  import lut_kmul_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int PROD_W  = 24,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_mode,
  input  logic [2*SEG_W-1:0]     in_operand,
  input  logic                   wr_en,
  input  logic [NUM_BANKS-1:0]   wr_bank,
  input  logic [SEG_W-1:0]       wr_addr,
  input  logic [PROD_W-1:0]      wr_data,
  output logic                   out_valid,
  output logic [PROD_W-1:0]      out_product
);
  localparam int OP_W = 2 * SEG_W;

  logic            s_valid;
  kmode_e          s_mode;
  logic [OP_W-1:0] s_operand;

  lut_kmul_instage #(.OP_W(OP_W), .REG_EN(IN_REG)) u_in (
    .clk       (clk),
    .rst       (rst),
    .i_valid   (in_valid),
    .i_mode    (kmode_e'(in_mode)),
    .i_operand (in_operand),
    .o_valid   (s_valid),
    .o_mode    (s_mode),
    .o_operand (s_operand)
  );

  logic   rd_valid;
  kmode_e rd_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_mode  <= MODE_SHORT_COEF;
    end else begin
      rd_valid <= s_valid;
      if (s_valid) rd_mode <= s_mode;
    end
  end

  logic [PROD_W-1:0] entry [NUM_BANKS];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      lut_kmul_bank #(.AW(SEG_W), .DW(PROD_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && wr_bank[b]),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (s_valid),
        .rd_addr (s_operand[b*SEG_W +: SEG_W]),
        .rd_data (entry[b])
      );
    end
  endgenerate

  lut_kmul_sum #(.SEG_W(SEG_W), .PROD_W(PROD_W), .REG_EN(OUT_REG)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .i_valid   (rd_valid),
    .i_mode    (rd_mode),
    .i_lo      (entry[0]),
    .i_hi      (entry[1]),
    .o_valid   (out_valid),
    .o_product (out_product)
  );

  // R8: the product only moves together with a valid result
  a_r8_top_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_product));
endmodule

// File: tb/lut_kmul_test.sv
module lut_kmul_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [15:0] in_operand = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_bank = '0;
  logic [7:0]  wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        out_valid;
  logic [23:0] out_product;

  always #4 clk = ~clk;

  lut_kmul uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
    .in_operand(in_operand), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
    .out_product(out_product)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] t0 [256];
  logic [23:0] t1 [256];
  logic [23:0] exp_q [16];
  string       tag_q [16];
  int wp = 0;
  int rp = 0;
  logic [23:0] last_exp = '0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: compare each valid result with the in-order expectation list (R5)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rp == wp) begin
        check(1'b0, "R5 unexpected out_valid", out_product, 24'd0);
      end else begin
        check(out_product == exp_q[rp % 16], tag_q[rp % 16], out_product, exp_q[rp % 16]);
        last_exp = exp_q[rp % 16];
        rp++;
      end
    end
  end

  task automatic write_entry(input logic [1:0] mask, input int addr, input logic [23:0] data);
    wr_en = 1'b1; wr_bank = mask; wr_addr = addr[7:0]; wr_data = data;
    if (mask[0]) t0[addr] = data;
    if (mask[1]) t1[addr] = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_table(input logic [1:0] mask, input int k);
    for (int i = 0; i < 256; i++) write_entry(mask, i, 24'(k * i));
  endtask

  task automatic issue(input bit mode, input logic [15:0] op, input logic [23:0] exp, input string req);
    in_valid = 1'b1; in_mode = mode; in_operand = op;
    exp_q[wp % 16] = exp; tag_q[wp % 16] = req; wp++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] model(input bit mode, input logic [15:0] op);
    if (mode) return t0[op[7:0]];
    return (t1[op[15:8]] << 8) + t0[op[7:0]];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid in reset", 24'(out_valid), 24'd0);
    check(out_product == 24'd0, "R1 product in reset", out_product, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_product == 24'd0, "R1 after reset", out_product, 24'd0);

    // R4, R2: coefficient 183 in both banks, full 16-bit sweep
    load_table(2'b11, 183);
    for (int op = 0; op < 65536; op++) issue(1'b0, 16'(op), 24'(183 * op), "R2 sweep");
    idle(6);

    // R7: extreme in short-coefficient mode
    load_table(2'b11, 255);
    issue(1'b0, 16'hFFFF, 24'd16711425, "R7 255x65535");
    issue(1'b0, 16'h0000, 24'd0, "R7 zero");
    idle(6);

    // R3, R7: long coefficient in bank 0 only, high byte scrambled
    load_table(2'b01, 65535);
    for (int x = 0; x < 256; x++)
      issue(1'b1, {8'(x ^ 8'h5A), 8'(x)}, 24'(65535 * x), "R3 long sweep");
    idle(6);
    // R4: bank 1 untouched by the bank-0-only load, mixed modes back to back
    for (int x = 0; x < 64; x++) begin
      issue(1'b0, {8'(x), 8'(x * 3)}, model(1'b0, {8'(x), 8'(x * 3)}), "R4 bank select");
      issue(1'b1, {8'(x), 8'(x * 3)}, model(1'b1, {8'(x), 8'(x * 3)}), "R3 mixed");
    end
    idle(6);

    // R6: rewrite entries while streaming, then look them up the next cycle
    for (int i = 0; i < 16; i++) begin
      issue(1'b0, 16'(i * 257), model(1'b0, 16'(i * 257)), "R6 before");
      in_valid = 1'b0;
      write_entry(2'b11, i, 24'(1000 + i));
      issue(1'b0, 16'(i * 257), (24'(1000 + i) << 8) + 24'(1000 + i), "R6 after write");
    end
    idle(6);

    // R5: latency from a lone operand
    begin
      int lat = 0;
      in_valid = 1'b1; in_mode = 1'b1; in_operand = 16'h0007;
      exp_q[wp % 16] = model(1'b1, 16'h0007); tag_q[wp % 16] = "R5 lone"; wp++;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_valid && lat < 10) begin
        @(negedge clk);
        lat++;
      end
      check(lat == 3, "R5 latency", 24'(lat), 24'd3);
    end
    idle(8);
    check(rp == wp, "R5 count", 24'(rp), 24'(wp));

    // R8: product holds while idle
    check(out_valid == 1'b0, "R8 idle valid", 24'(out_valid), 24'd0);
    check(out_product == last_exp, "R8 hold", out_product, last_exp);
    done = 1'b1;
    summary();
  end
endmodule